// File: doc/BRIEF.md
# DMA Channel Event Sorter

This block gathers per-channel completion and error events for a sixteen-channel DMA engine. It keeps them in two flag registers that software reaches through a simple register port, and it drives one interrupt line. Each flag register can be written through four aliases: replace, set-bits, clear-bits and toggle-bits. Channel events arrive as one-cycle pulses from the engine.

The block qualifies the raw error flags. A termination error on a channel that also completed is not an error. A bus error is always an error. The qualified errors and the raw completions form one pending vector, with errors in the upper half. A small state machine serves the highest set bit of that vector. It presents the channel number and the event kind, and holds them until software acknowledges. For a completion, the acknowledge clears that channel's completion flag. For an error, it clears both of that channel's error flags and sends a one-cycle reset pulse to the channel.

State machine: `ST_IDLE` waits for a pending bit and takes the transition *capture* to `ST_REPORT`, latching the winning index. `ST_REPORT` presents the event. On acknowledge it takes *finish* back to `ST_IDLE` for a completion, or *recover* to `ST_RESET` for an error. `ST_RESET` drives the channel reset for one cycle and takes *rearm* back to `ST_IDLE`.

Top module: `dma_evt_sorter`

## Requirements
- R1: After reset, every flag and enable bit reads 0, `irq` is low, `evt_valid` is low and `chan_reset` is 0.
- R2: A `done_pulse[i]` sets bit i of the completion register (offset 0x010, bits 15:0). A `term_pulse[i]` sets bit i of the error register (offset 0x020). A `bus_err_pulse[i]` sets both bit i and bit 16+i of the error register. Bits 31:16 of the completion register are the per-channel interrupt enables.
- R3: A write to register base+0x0 replaces its contents. Base+0x4 ORs in the data, base+0x8 clears the bits set in the data, and base+0xC inverts them. All four aliases read back the register.
- R4: An event pulse in the same cycle as a clear or replace write to the same bit leaves the bit set.
- R5: Channel i is in error when bit 16+i and bit i of the error register are both set. It is also in error when bit i is set, bit 16+i is clear and completion bit i is clear. A termination flag alongside a completion is therefore not an error.
- R6: `irq` is high exactly when some completion bit with its enable set exists, or some channel is in error. It follows the flags with no added register stage.
- R7: The pending vector is {qualified errors, completion flags}, and its highest set bit is served first. Any error outranks any completion, and a higher channel outranks a lower one.
- R8: One clock edge after a pending bit is visible in `ST_IDLE`, `evt_valid` rises with `evt_chan` and `evt_is_err` (1 = error). These stay unchanged until an acknowledge, which is a write to offset 0x000 with bit 0 set.
- R9: The acknowledge of a completion clears that completion flag. The acknowledge of an error clears both error flags of that channel, and `chan_reset` is then one-hot on that channel for exactly one cycle. `chan_reset` is never driven otherwise.
- R10: An acknowledge while `evt_valid` is low changes no flag and starts no reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| done_pulse | input | 16 | Per-channel completion pulses |
| term_pulse | input | 16 | Per-channel termination-error pulses |
| bus_err_pulse | input | 16 | Per-channel bus-error pulses |
| irq | output | 1 | Interrupt request |
| evt_valid | output | 1 | An event is being presented |
| evt_chan | output | 4 | Channel of the presented event |
| evt_is_err | output | 1 | Presented event is an error |
| chan_reset | output | 16 | One-cycle per-channel reset pulse |

## Verification
A flag is due, and so is the effect on `irq`, right after the edge that samples its pulse or write. Read data is combinational, so it is checked a moment after the address settles. `evt_valid` with its channel and kind is due one edge later. After an error acknowledge, the reset pulse appears after the next edge and is gone one edge after that. The bench drives inputs on falling edges and compares every output there against a behavioural model that advances on rising edges. The directed checks wait the exact number of falling edges these latencies give.

// File: rtl/des_pkg.sv
package des_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REPORT = 2'd1,
        ST_RESET  = 2'd2
    } des_state_e;

    typedef enum logic [1:0] {
        ALIAS_WRITE  = 2'd0,
        ALIAS_SET    = 2'd1,
        ALIAS_CLEAR  = 2'd2,
        ALIAS_TOGGLE = 2'd3
    } des_alias_e;

endpackage

// File: rtl/des_flag_reg.sv
module des_flag_reg
    import des_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter int unsigned AW   = 12,
    parameter logic [11:0] BASE = 12'h010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  hw_clr,
    input  logic [W-1:0]  hw_set,
    output logic [W-1:0]  q
);
    logic       hit;
    des_alias_e op;
    logic [W-1:0] nxt;

    assign hit = wr_en && (wr_addr[AW-1:4] == BASE[AW-1:4]) && (wr_addr[1:0] == 2'b00);
    assign op  = des_alias_e'(wr_addr[3:2]);

    always_comb begin
        nxt = q;
        if (hit) begin
            unique case (op)
                ALIAS_WRITE:  nxt = wr_data;
                ALIAS_SET:    nxt = q | wr_data;
                ALIAS_CLEAR:  nxt = q & ~wr_data;
                ALIAS_TOGGLE: nxt = q ^ wr_data;
                default:      nxt = q;
            endcase
        end
        // hardware pulses are applied last so they win over any clear
        nxt = (nxt & ~hw_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/des_qualify.sv
module des_qualify #(
    parameter int unsigned NCH = 16
) (
    input  logic [NCH-1:0]   done,
    input  logic [NCH-1:0]   term,
    input  logic [NCH-1:0]   bus,
    output logic [NCH-1:0]   err_ok,
    output logic [2*NCH-1:0] pending
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign err_ok[c] = term[c] & (bus[c] | ~done[c]);
    end
    assign pending = {err_ok, done};
endmodule

// File: rtl/des_prio.sv
module des_prio #(
    parameter int unsigned W    = 32,
    parameter int unsigned IDXW = $clog2(W)
) (
    input  logic [W-1:0]    vec,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/des_fsm.sv
module des_fsm
    import des_pkg::*;
#(
    parameter int unsigned NCH  = 16,
    parameter int unsigned IDXW = 5,
    parameter int unsigned CHW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_any,
    input  logic [IDXW-1:0] pend_idx,
    input  logic            ack,
    output logic            evt_valid,
    output logic [CHW-1:0]  evt_chan,
    output logic            evt_is_err,
    output logic [NCH-1:0]  done_clr,
    output logic [NCH-1:0]  err_clr,
    output logic [NCH-1:0]  chan_reset
);
    des_state_e state_q, state_d;
    logic [CHW-1:0] chan_q;
    logic           kind_q;
    logic [NCH-1:0] chan_oh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            kind_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pend_any) begin
                chan_q <= pend_idx[CHW-1:0];
                kind_q <= pend_idx[IDXW-1];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pend_any) state_d = ST_REPORT;
            ST_REPORT: if (ack)      state_d = kind_q ? ST_RESET : ST_IDLE;
            ST_RESET:                state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        chan_oh    = {{(NCH-1){1'b0}}, 1'b1} << chan_q;
        evt_valid  = (state_q == ST_REPORT);
        evt_chan   = chan_q;
        evt_is_err = kind_q;
        done_clr   = (evt_valid && ack && !kind_q) ? chan_oh : '0;
        err_clr    = (evt_valid && ack &&  kind_q) ? chan_oh : '0;
        chan_reset = (state_q == ST_RESET) ? chan_oh : '0;
    end
endmodule

// File: rtl/dma_evt_sorter.sv
module dma_evt_sorter #(
    parameter int unsigned NCH      = 16,
    parameter int unsigned AW       = 12,
    parameter logic [11:0] CTRL_OFS = 12'h000,
    parameter logic [11:0] DONE_OFS = 12'h010,
    parameter logic [11:0] ERR_OFS  = 12'h020
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [2*NCH-1:0]   reg_wdata,
    output logic [2*NCH-1:0]   reg_rdata,
    input  logic [NCH-1:0]     done_pulse,
    input  logic [NCH-1:0]     term_pulse,
    input  logic [NCH-1:0]     bus_err_pulse,
    output logic               irq,
    output logic               evt_valid,
    output logic [$clog2(NCH)-1:0] evt_chan,
    output logic               evt_is_err,
    output logic [NCH-1:0]     chan_reset
);
    localparam int unsigned DW   = 2 * NCH;
    localparam int unsigned IDXW = $clog2(DW);
    localparam int unsigned CHW  = $clog2(NCH);

    logic [DW-1:0]  cmpl_reg_q;
    logic [DW-1:0]  err_reg_q;
    logic [NCH-1:0] done_clr, err_clr;
    logic [NCH-1:0] err_ok;
    logic [DW-1:0]  pending;
    logic           pend_any;
    logic [IDXW-1:0] pend_idx;
    logic           ack_fire;

    assign ack_fire = reg_wr && (reg_addr == CTRL_OFS[AW-1:0]) && reg_wdata[0];

    des_flag_reg #(.W(DW), .AW(AW), .BASE(DONE_OFS)) u_cmpl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .hw_clr  ({{NCH{1'b0}}, done_clr}),
        .hw_set  ({{NCH{1'b0}}, done_pulse}),
        .q       (cmpl_reg_q)
    );

    des_flag_reg #(.W(DW), .AW(AW), .BASE(ERR_OFS)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .hw_clr  ({err_clr, err_clr}),
        .hw_set  ({bus_err_pulse, term_pulse | bus_err_pulse}),
        .q       (err_reg_q)
    );

    des_qualify #(.NCH(NCH)) u_qual (
        .done    (cmpl_reg_q[NCH-1:0]),
        .term    (err_reg_q[NCH-1:0]),
        .bus     (err_reg_q[DW-1:NCH]),
        .err_ok  (err_ok),
        .pending (pending)
    );

    des_prio #(.W(DW), .IDXW(IDXW)) u_prio (
        .vec (pending),
        .any (pend_any),
        .idx (pend_idx)
    );

    des_fsm #(.NCH(NCH), .IDXW(IDXW), .CHW(CHW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any   (pend_any),
        .pend_idx   (pend_idx),
        .ack        (ack_fire),
        .evt_valid  (evt_valid),
        .evt_chan   (evt_chan),
        .evt_is_err (evt_is_err),
        .done_clr   (done_clr),
        .err_clr    (err_clr),
        .chan_reset (chan_reset)
    );

    assign irq = (|(cmpl_reg_q[DW-1:NCH] & cmpl_reg_q[NCH-1:0])) | (|err_ok);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[1:0] == 2'b00) begin
            if (reg_addr[AW-1:4] == DONE_OFS[AW-1:4])     reg_rdata = cmpl_reg_q;
            else if (reg_addr[AW-1:4] == ERR_OFS[AW-1:4]) reg_rdata = err_reg_q;
        end
    end
endmodule

// File: rtl/dma_evt_sorter_chk.sv
module dma_evt_sorter_chk #(
    parameter int unsigned NCH = 16,
    parameter int unsigned CHW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ack_fire,
    input logic [NCH-1:0] done_pulse,
    input logic [NCH-1:0] bus_err_pulse,
    input logic [NCH-1:0] done_flags,
    input logic           irq,
    input logic           evt_valid,
    input logic [CHW-1:0] evt_chan,
    input logic           evt_is_err,
    input logic [NCH-1:0] chan_reset
);
    localparam logic [NCH-1:0] ONE = {{(NCH-1){1'b0}}, 1'b1};

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !ack_fire |=> evt_valid && $stable(evt_chan) && $stable(evt_is_err)); // R8
    AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_reset)); // R9
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_reset) |=> chan_reset == '0); // R9
    AST_RST_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_is_err && ack_fire |=> chan_reset == (ONE << $past(evt_chan))); // R9
    AST_RST_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_reset) |-> $past(evt_valid && evt_is_err && ack_fire)); // R9
    AST_BUS_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_err_pulse) |=> irq); // R5
    AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_pulse) |=> ((done_flags & $past(done_pulse)) == $past(done_pulse))); // R4
endmodule

bind dma_evt_sorter dma_evt_sorter_chk #(.NCH(NCH), .CHW($clog2(NCH))) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_fire      (ack_fire),
    .done_pulse    (done_pulse),
    .bus_err_pulse (bus_err_pulse),
    .done_flags    (cmpl_reg_q[NCH-1:0]),
    .irq           (irq),
    .evt_valid     (evt_valid),
    .evt_chan      (evt_chan),
    .evt_is_err    (evt_is_err),
    .chan_reset    (chan_reset)
);

// File: tb/test_dma_evt_sorter.sv
`timescale 1ns/1ps
module test_dma_evt_sorter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] done_pulse = '0, term_pulse = '0, bus_err_pulse = '0;
    logic        irq, evt_valid, evt_is_err;
    logic [3:0]  evt_chan;
    logic [15:0] chan_reset;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_evt_sorter i_dma_evt_sorter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_pulse(done_pulse),
        .term_pulse(term_pulse), .bus_err_pulse(bus_err_pulse), .irq(irq),
        .evt_valid(evt_valid), .evt_chan(evt_chan), .evt_is_err(evt_is_err),
        .chan_reset(chan_reset)
    );

    // behavioural reference model
    logic [15:0] m_done, m_en, m_term, m_bus;
    int          m_st;
    int          m_chan;
    bit          m_err;
    logic [15:0] qe;
    logic [31:0] mv, dreg, ereg;
    int          hi;

    function automatic logic [31:0] alias_op(logic [31:0] old, logic [1:0] op, logic [31:0] d);
        case (op)
            2'd0: return d;
            2'd1: return old | d;
            2'd2: return old & ~d;
            default: return old ^ d;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_done = '0; m_en = '0; m_term = '0; m_bus = '0;
            m_st = 0; m_chan = 0; m_err = 1'b0;
        end else begin
            qe = (m_bus & m_term) | (~m_bus & m_term & ~m_done);
            mv = {qe, m_done};
            hi = -1;
            for (int i = 0; i < 32; i++) if (mv[i]) hi = i;
            dreg = {m_en, m_done};
            ereg = {m_bus, m_term};
            if (reg_wr && reg_addr[11:4] == 8'h01 && reg_addr[1:0] == 2'b00)
                dreg = alias_op(dreg, reg_addr[3:2], reg_wdata);
            if (reg_wr && reg_addr[11:4] == 8'h02 && reg_addr[1:0] == 2'b00)
                ereg = alias_op(ereg, reg_addr[3:2], reg_wdata);
            case (m_st)
                0: if (hi >= 0) begin m_st = 1; m_chan = hi % 16; m_err = (hi >= 16); end
                1: if (reg_wr && reg_addr == 12'h000 && reg_wdata[0]) begin
                       if (m_err) ereg = ereg & ~((32'd1 << (m_chan + 16)) | (32'd1 << m_chan));
                       else       dreg = dreg & ~(32'd1 << m_chan);
                       m_st = m_err ? 2 : 0;
                   end
                default: m_st = 0;
            endcase
            dreg = dreg | {16'h0, done_pulse};
            ereg = ereg | {bus_err_pulse, term_pulse | bus_err_pulse};
            m_en = dreg[31:16]; m_done = dreg[15:0];
            m_bus = ereg[31:16]; m_term = ereg[15:0];
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] q2;
            logic        exp_irq;
            q2 = (m_bus & m_term) | (~m_bus & m_term & ~m_done);
            exp_irq = (|(m_en & m_done)) | (|q2);
            chk(irq === exp_irq, "R6 irq", {31'b0, irq}, {31'b0, exp_irq});
            chk(evt_valid === (m_st == 1), "R8 evt_valid", {31'b0, evt_valid}, {31'b0, m_st == 1});
            if (m_st == 1) begin
                chk(evt_chan === 4'(m_chan), "R7 evt_chan", {28'b0, evt_chan}, 32'(m_chan));
                chk(evt_is_err === m_err, "R7 evt_is_err", {31'b0, evt_is_err}, {31'b0, m_err});
            end
            chk(chan_reset === ((m_st == 2) ? (16'd1 << m_chan) : 16'd0), "R9 chan_reset",
                {16'b0, chan_reset}, (m_st == 2) ? (32'd1 << m_chan) : 32'd0);
        end
    end

    // one stimulus cycle, then everything back to idle
    task automatic act(bit w, logic [11:0] a, logic [31:0] d,
                       logic [15:0] dp, logic [15:0] tp, logic [15:0] bp);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        done_pulse = dp; term_pulse = tp; bus_err_pulse = bp;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        done_pulse = '0; term_pulse = '0; bus_err_pulse = '0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic ack();
        act(1'b1, 12'h000, 32'h1, '0, '0, '0);
    endtask

    task automatic see_evt(logic [3:0] ch, bit e, string tag);
        chk(evt_valid === 1'b1, tag, {31'b0, evt_valid}, 32'd1);
        chk(evt_chan === ch && evt_is_err === e, tag, {27'b0, evt_is_err, evt_chan}, {27'b0, e, ch});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h010, 32'h0, "R1 completion reg");
        rd(12'h020, 32'h0, "R1 error reg");
        chk(irq === 1'b0 && evt_valid === 1'b0 && chan_reset === '0, "R1 outputs",
            {15'b0, chan_reset, irq}, 32'h0);

        // R3 set alias loads all enables
        act(1'b1, 12'h014, 32'hFFFF_0000, '0, '0, '0);
        rd(12'h010, 32'hFFFF_0000, "R3 set alias");

        // R2/R6/R8/R9 completion on channel 3
        act(1'b0, 12'h010, 0, 16'h0008, '0, '0);
        chk(irq === 1'b1, "R6 enabled completion", {31'b0, irq}, 32'd1);
        rd(12'h010, 32'hFFFF_0008, "R2 completion flag");
        @(negedge clk);
        see_evt(4'd3, 1'b0, "R8 completion event");
        ack();
        rd(12'h010, 32'hFFFF_0000, "R9 completion cleared");

        // R5 termination together with completion on channel 5
        act(1'b0, 12'h010, 0, 16'h0020, 16'h0020, '0);
        rd(12'h020, 32'h0000_0020, "R2 termination flag");
        @(negedge clk);
        see_evt(4'd5, 1'b0, "R5 suppressed termination");
        ack();
        @(negedge clk);
        see_evt(4'd5, 1'b1, "R5 termination alone is error");
        ack();
        chk(chan_reset === 16'h0020, "R9 reset pulse ch5", {16'b0, chan_reset}, 32'h20);
        rd(12'h020, 32'h0, "R9 error flags cleared");
        @(negedge clk);
        chk(chan_reset === 16'h0, "R9 pulse one cycle", {16'b0, chan_reset}, 32'h0);

        // R7 error outranks completion; bus error always reported
        act(1'b0, 12'h010, 0, 16'h0200, '0, 16'h0004);
        rd(12'h020, 32'h0004_0004, "R2 bus error sets both bits");
        @(negedge clk);
        see_evt(4'd2, 1'b1, "R7 error before completion");
        ack();
        chk(chan_reset === 16'h0004, "R9 reset pulse ch2", {16'b0, chan_reset}, 32'h4);
        @(negedge clk);
        @(negedge clk);
        see_evt(4'd9, 1'b0, "R7 then completion ch9");
        ack();

        // R7 higher channel first
        act(1'b0, 12'h010, 0, 16'h4002, '0, '0);
        @(negedge clk);
        see_evt(4'd14, 1'b0, "R7 ch14 before ch1");
        ack();
        @(negedge clk);
        see_evt(4'd1, 1'b0, "R7 ch1 next");
        ack();

        // R4 pulse beats a clear to the same bit
        act(1'b1, 12'h018, 32'h0000_0080, 16'h0080, '0, '0);
        rd(12'h010, 32'hFFFF_0080, "R4 pulse wins over clear");
        @(negedge clk);
        see_evt(4'd7, 1'b0, "R4 event ch7");
        ack();

        // R3 clear alias alone
        act(1'b0, 12'h010, 0, 16'h0100, '0, '0);
        act(1'b1, 12'h018, 32'h0000_0100, '0, '0, '0);
        rd(12'h010, 32'hFFFF_0000, "R3 clear alias");
        ack();

        // R3 toggle and replace
        act(1'b1, 12'h01C, 32'h0F0F_0000, '0, '0, '0);
        rd(12'h01C, 32'hF0F0_0000, "R3 toggle alias");
        act(1'b1, 12'h010, 32'h1234_0000, '0, '0, '0);
        rd(12'h010, 32'h1234_0000, "R3 replace");

        // R3 error register aliases
        act(1'b1, 12'h024, 32'h0001_0001, '0, '0, '0);
        rd(12'h020, 32'h0001_0001, "R3 error set alias");
        @(negedge clk);
        see_evt(4'd0, 1'b1, "R5 bus error ch0");
        act(1'b1, 12'h028, 32'h0001_0001, '0, '0, '0);
        rd(12'h020, 32'h0, "R3 error clear alias");
        ack();
        @(negedge clk);

        // R6 completion with enable off gives no irq
        act(1'b0, 12'h010, 0, 16'h0001, '0, '0);
        chk(irq === 1'b0, "R6 disabled completion", {31'b0, irq}, 32'd0);
        @(negedge clk);
        see_evt(4'd0, 1'b0, "R7 disabled completion still served");
        ack();
        @(negedge clk);

        // R10 acknowledge while idle
        ack();
        rd(12'h010, 32'h1234_0000, "R10 completion reg kept");
        rd(12'h020, 32'h0, "R10 error reg kept");
        chk(evt_valid === 1'b0 && chan_reset === '0, "R10 no event",
            {15'b0, chan_reset, evt_valid}, 32'h0);
        @(negedge clk);
        chk(chan_reset === '0, "R10 no reset pulse", {16'b0, chan_reset}, 32'h0);

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule